// File: doc/BRIEF.md
# Hardware task switch sequencer

This control unit performs a complete processor context switch between task state records kept in word-addressed memory. A request carries a kind code, a target selector and a target offset. The offset plays no part. The kinds are: load the task register, a call-type switch, a jump-type switch, and a nested return. For a switch, the unit first fetches the target's descriptor from a descriptor table at a fixed base. It then writes the live register snapshot into the outgoing record and adjusts the busy bits in both descriptors. Next it reads the incoming record into its snapshot output. For a call it also records the caller in the callee's back-link word.

A call marks the callee busy and leaves the caller busy. It sets the nested-task flag in the loaded flags word, so that a later return can find its way back through the back-link. A jump releases the outgoing task and touches neither the flag nor the back-link. A return is only legal while the nested-task flag is set in the live flags. It reads its target from the current record's back-link and releases the task it leaves. Illegal requests end in a fault pulse before any memory word is written.

Top module: `task_switch_seq`

## Requirements
- R1: Each memory transfer holds `mem_req` high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until a cycle in which `mem_ack` is high. That cycle completes the transfer, and for a read `mem_rdata` is taken in that cycle.
- R2: The descriptor for selector `s` sits at byte address `DT_BASE + 8*s[15:3]`. Its first word holds record base bits 15:0 in bits 31:16. Its second word holds base bits 23:16 in bits 7:0, base bits 31:24 in bits 31:24, and the 4-bit type in bits 11:8. Type 9 is available, 11 is busy, and the busy flag is bit 9 of that word. Snapshot word i (bits 32i+31:32i) maps to record byte offset 28+4i. The words in order are: page-directory base, instruction pointer, flags, the general registers A, C, D, B, SP, BP, SI, DI, the selectors ES, CS, SS, DS, FS, GS, and the local-descriptor selector.
- R3: `kind` codes are 0 = load task register, 1 = call, 2 = jump, 3 = return. `offset` has no effect. A request is taken only when the unit is idle, and this includes the cycle in which `done` is high.
- R4: A load-task-register request reads only the two descriptor words and writes nothing. It then sets `tr` to the selector, leaves `rf_out` unchanged and pulses `done`.
- R5: A call or jump whose target descriptor type is not 9 pulses `fault` and writes no memory. It also leaves `tr` and `rf_out` unchanged.
- R6: A switch writes the 18 words of `rf_in` to the outgoing record at ascending offsets 28 to 96. It then reads the incoming record's words at ascending offsets 28 to 96 into `rf_out`.
- R7: A call writes the incoming descriptor with busy set and leaves the outgoing descriptor as it is. It sets the nested-task flag (flags bit 14, mask 0x00004000, `rf_out` bit 78) in the loaded flags. After the load, it writes `{16'h0, old tr}` to the incoming record's back-link word at offset 0.
- R8: A jump clears busy in the outgoing descriptor and sets busy in the incoming one. It loads the flags word exactly as stored and does not write the back-link word.
- R9: A return with `rf_in` bit 78 set switches to the selector in the low 16 bits of the current record's word at offset 0. It clears the outgoing busy bit and writes the incoming descriptor with busy set. It does not write any back-link. A return with bit 78 clear pulses `fault` and touches no memory.
- R10: After every switch `tr` holds the incoming selector. `done` and `fault` are each single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| kind | input | 2 | Request kind code |
| sel | input | 16 | Target selector |
| offset | input | 32 | Target offset, unused |
| rf_in | input | 576 | Live register snapshot, 18 words |
| rf_out | output | 576 | Loaded register snapshot |
| tr | output | 16 | Task register |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Abort pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The completion pulse of one request and the acceptance of the next can fall in the same cycle, because the unit is already idle while `done` is high. The bench issues every new request in exactly the cycle in which it sees `done` or `fault`, with the memory acknowledging after random delays. It then judges the second request by its own outcome: the expected status, task register, snapshot and the complete memory image all come from a bench model of the requirements.

// File: rtl/task_switch_seq.sv
module task_switch_seq #(
  parameter logic [31:0] DT_BASE = 32'h0000_0800,
  localparam int NW = 18,
  localparam int RFW = NW * 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [1:0]     kind,
  input  logic [15:0]    sel,
  input  logic [31:0]    offset,
  input  logic [RFW-1:0] rf_in,
  output logic [RFW-1:0] rf_out,
  output logic [15:0]    tr,
  output logic           done,
  output logic           fault,
  output logic           mem_req,
  output logic           mem_we,
  output logic [31:0]    mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic [31:0]    mem_rdata,
  input  logic           mem_ack
);

  localparam logic [1:0]  K_LTR = 2'd0, K_CALL = 2'd1, K_JMP = 2'd2, K_RET = 2'd3;
  localparam logic [4:0]  LAST = 5'(NW - 1);
  localparam logic [4:0]  FLAG_W = 5'd2;
  localparam int          NT_BIT = 32 * 2 + 14;
  localparam logic [31:0] NT_MASK = 32'h0000_4000;
  localparam logic [31:0] BUSY = 32'h0000_0200;
  localparam logic [31:0] REC_OFS = 32'd28;

  typedef enum logic [3:0] {
    S_IDLE, S_BLR, S_DLO, S_DHI, S_CHK, S_SAVE, S_OCLR, S_ISET, S_LOAD, S_BLW
  } st_t;

  st_t            st;
  logic [4:0]     idx;
  logic [1:0]     kq;
  logic [15:0]    tr_q, nsel, nlo;
  logic [31:0]    cur_base, cur_dhi, ndhi;
  logic [RFW-1:0] rf_q;
  logic           done_q, fault_q;

  logic [31:0] daddr, cur_dhi_addr, nbase, word_ofs;
  logic [9:0]  woff;
  logic        unused_ok;

  assign daddr        = DT_BASE + {16'h0, nsel[15:3], 3'b000};
  assign cur_dhi_addr = DT_BASE + {16'h0, tr_q[15:3], 3'b000} + 32'd4;
  assign nbase        = {ndhi[31:24], ndhi[7:0], nlo};
  assign word_ofs     = REC_OFS + {25'h0, idx, 2'b00};
  assign woff         = {idx, 5'b00000};
  assign unused_ok    = ^offset;

  assign rf_out = rf_q;
  assign tr     = tr_q;
  assign done   = done_q;
  assign fault  = fault_q;

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = 32'h0;
    mem_wdata = 32'h0;
    case (st)
      S_BLR:  mem_addr = cur_base;
      S_DLO:  mem_addr = daddr;
      S_DHI:  mem_addr = daddr + 32'd4;
      S_SAVE: begin
        mem_we    = 1'b1;
        mem_addr  = cur_base + word_ofs;
        mem_wdata = rf_q[woff +: 32];
      end
      S_OCLR: begin
        mem_we    = 1'b1;
        mem_addr  = cur_dhi_addr;
        mem_wdata = cur_dhi & ~BUSY;
      end
      S_ISET: begin
        mem_we    = 1'b1;
        mem_addr  = daddr + 32'd4;
        mem_wdata = ndhi | BUSY;
      end
      S_LOAD: mem_addr = nbase + word_ofs;
      S_BLW: begin
        mem_we    = 1'b1;
        mem_addr  = nbase;
        mem_wdata = {16'h0, tr_q};
      end
      default: mem_req = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; kq <= K_LTR;
      tr_q <= '0; nsel <= '0; nlo <= '0;
      cur_base <= '0; cur_dhi <= '0; ndhi <= '0;
      rf_q <= '0; done_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          kq   <= kind;
          nsel <= sel;
          if (kind != K_RET)      st <= S_DLO;
          else if (rf_in[NT_BIT]) st <= S_BLR;
          else                    fault_q <= 1'b1;
        end
        S_BLR: if (mem_ack) begin
          nsel <= mem_rdata[15:0];
          st   <= S_DLO;
        end
        S_DLO: if (mem_ack) begin
          nlo <= mem_rdata[31:16];
          st  <= S_DHI;
        end
        S_DHI: if (mem_ack) begin
          ndhi <= mem_rdata;
          if (kq == K_LTR) begin
            tr_q     <= nsel;
            cur_base <= {mem_rdata[31:24], mem_rdata[7:0], nlo};
            cur_dhi  <= mem_rdata;
            done_q   <= 1'b1;
            st       <= S_IDLE;
          end else st <= S_CHK;
        end
        S_CHK: begin
          if (kq != K_RET && ndhi[11:8] != 4'h9) begin
            fault_q <= 1'b1;
            st      <= S_IDLE;
          end else begin
            rf_q <= rf_in;
            idx  <= '0;
            st   <= S_SAVE;
          end
        end
        S_SAVE: if (mem_ack) begin
          if (idx == LAST) begin
            idx <= '0;
            st  <= (kq == K_CALL) ? S_ISET : S_OCLR;
          end else idx <= idx + 5'd1;
        end
        S_OCLR: if (mem_ack) st <= S_ISET;
        S_ISET: if (mem_ack) st <= S_LOAD;
        S_LOAD: if (mem_ack) begin
          rf_q[woff +: 32] <= (idx == FLAG_W && kq == K_CALL) ? (mem_rdata | NT_MASK) : mem_rdata;
          if (idx != LAST) idx <= idx + 5'd1;
          else if (kq == K_CALL) st <= S_BLW;
          else begin
            tr_q <= nsel; cur_base <= nbase; cur_dhi <= ndhi | BUSY;
            done_q <= 1'b1; st <= S_IDLE;
          end
        end
        S_BLW: if (mem_ack) begin
          tr_q <= nsel; cur_base <= nbase; cur_dhi <= ndhi | BUSY;
          done_q <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r4_ltr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (kq == K_LTR && st != S_IDLE) |-> !(mem_req && mem_we));

  a_r5_fault_keeps_tr: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(tr_q));

  a_r7_call_sets_nt: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kq == K_CALL) |-> rf_q[NT_BIT]);

  a_r10_done_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fault);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_task_switch_seq.sv
module sim_task_switch_seq;
  localparam int RFW = 576;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] kind = 2'd0;
  logic [15:0] sel = 16'h0;
  logic [31:0] offset = 32'h0;
  logic [RFW-1:0] rf_in = '0;
  logic [RFW-1:0] rf_out;
  logic [15:0] tr;
  logic done, fault, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  logic [31:0] emem [0:1023];
  logic [15:0] exp_tr;
  logic [31:0] exp_base;
  logic [RFW-1:0] exp_rf;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  task_switch_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .sel(sel), .offset(offset),
    .rf_in(rf_in), .rf_out(rf_out), .tr(tr), .done(done), .fault(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  initial begin
    mem_ack = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        repeat ($urandom_range(0, 2)) @(negedge clk);
        if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[11:2]];
        mem_ack = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [RFW-1:0] act, input logic [RFW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [RFW-1:0] rand_rf(input bit nt);
    logic [RFW-1:0] r;
    for (int i = 0; i < 18; i++) r[i*32 +: 32] = $urandom;
    r[78] = nt;
    return r;
  endfunction

  task automatic predict(input logic [1:0] k, input logic [15:0] s_in,
                         input logic [RFW-1:0] r, output bit f);
    logic [15:0] s;
    logic [31:0] dl, dh, nb;
    int di;
    s = s_in;
    f = 1'b0;
    if (k == 2'd3) begin
      if (!r[78]) begin f = 1'b1; return; end
      s = emem[exp_base[11:2]][15:0];
    end
    di = 512 + 2 * int'(s[15:3]);
    dl = emem[di];
    dh = emem[di + 1];
    if ((k == 2'd1 || k == 2'd2) && dh[11:8] != 4'h9) begin f = 1'b1; return; end
    nb = {dh[31:24], dh[7:0], dl[31:16]};
    if (k == 2'd0) begin exp_tr = s; exp_base = nb; return; end
    for (int i = 0; i < 18; i++) emem[(exp_base[11:2] + 7 + i) % 1024] = r[i*32 +: 32];
    if (k != 2'd1) emem[513 + 2 * int'(exp_tr[15:3])][9] = 1'b0;
    emem[di + 1][9] = 1'b1;
    for (int i = 0; i < 18; i++) exp_rf[i*32 +: 32] = emem[(nb[11:2] + 7 + i) % 1024];
    if (k == 2'd1) begin
      exp_rf[78] = 1'b1;
      emem[nb[11:2]] = {16'h0, exp_tr};
    end
    exp_tr = s;
    exp_base = nb;
  endtask

  task automatic run_op(input logic [1:0] k, input logic [15:0] s, input bit nt);
    bit f, got_d, got_f;
    int cyc, bad;
    string tag;
    logic [RFW-1:0] r;
    r = rand_rf(nt);
    tag = (k == 2'd0) ? "R4" : (k == 2'd1) ? "R7" : (k == 2'd2) ? "R8" : "R9";
    predict(k, s, r, f);
    if (f && k != 2'd3) tag = "R5";
    kind = k; sel = s; offset = $urandom; rf_in = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    got_d = done; got_f = fault;
    check(got_d != got_f && got_f == f, {tag, " R3"}, "status fault/done",
          {got_f, got_d}, {f, !f});
    check(tr === exp_tr, {tag, " R10"}, "task register", tr, exp_tr);
    check(rf_out === exp_rf, {tag, " R6"}, "loaded snapshot", rf_out, exp_rf);
    bad = -1;
    for (int i = 0; i < 1024; i++) if (mem[i] !== emem[i] && bad < 0) bad = i;
    check(bad < 0, {tag, " R1 R2"}, $sformatf("memory word %0d", bad),
          (bad < 0) ? 0 : mem[bad], (bad < 0) ? 0 : emem[bad]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R10 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = $urandom;
    for (int t = 0; t < 4; t++) begin
      logic [31:0] b;
      b = 32'h80 * t;
      mem[b[11:2]] = {16'h0, 16'((t + 2) % 4 * 8 + 8)};
      mem[514 + 2*t] = {b[15:0], 16'h0067};
      mem[515 + 2*t] = {b[31:24], 8'h00, (t == 0) ? 8'h8B : 8'h89, b[23:16]};
    end
    for (int i = 0; i < 1024; i++) emem[i] = mem[i];
    exp_tr = 16'h0; exp_base = 32'h0; exp_rf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !fault && !mem_req, "R1", "reset outputs", {done, fault, mem_req}, 0);
    check(tr == 16'h0 && rf_out == '0, "R10", "reset tr/snapshot", tr, 0);
    run_op(2'd0, 16'h0008, 1'b0);
    run_op(2'd1, 16'h0010, 1'b0);
    run_op(2'd1, 16'h0008, 1'b0);
    run_op(2'd3, 16'h0000, 1'b1);
    run_op(2'd3, 16'h0000, 1'b0);
    run_op(2'd2, 16'h0018, 1'b0);
    run_op(2'd2, 16'h0018, 1'b0);
    run_op(2'd1, 16'h0020, 1'b1);
    run_op(2'd3, 16'h0000, 1'b1);
    for (int n = 0; n < 60; n++)
      run_op(2'($urandom_range(1, 3)), 16'(8 * $urandom_range(1, 4)), $urandom_range(0, 3) != 0);
    run_op(2'd0, 16'h0010, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule